// File: doc/BRIEF.md
# Load/Store Queue Slot Allocator

This block tracks memory operations in flight between dispatch and retirement. It holds two rings, one for loads and one for stores. Each slot holds the 16-bit sequence number of one operation, and the slots stay in program order. Dispatch offers one operation per cycle. The block answers in the same cycle with the slot index that the operation would take. It also returns a cross-reference into the other ring: a load gets the store ring's tail, and a store gets the load ring's tail. It also reports how many more operations of either kind can be accepted.

Each ring is sized one slot larger than its usable capacity, so full and empty can be told apart from the pointers alone. A commit input carries the youngest retired sequence number. On commit, every load at or below that number leaves the load ring in one cycle. Stores at or below that number are only marked ready for writeback. A separate retire strobe then frees the oldest store once it is ready. A squash input rewinds both tails past every entry younger than the squash number. The store rewind halts at the first store already marked ready.

Top module: `lsq_alloc`

## Requirements
- R1: Each ring accepts at most its depth parameter (default 4) of live entries. A dispatch to a full ring gets `disp_accept` low and changes no state.
- R2: `disp_idx` gives the current tail of the target ring (`disp_is_store` 1 = store ring, 0 = load ring). Each accepted dispatch moves that tail up by one. The tail wraps from depth to 0, because the ring has depth+1 slots.
- R3: For a load, `disp_link_idx` gives the store ring tail. `disp_link_none` is 1 exactly when the store ring holds no entries.
- R4: For a store, `disp_link_idx` gives the load ring tail, and `disp_link_none` is 0.
- R5: `free_count` equals the smaller of (load depth − live loads) and (store depth − live stores).
- R6: When `commit_valid` is high, every load whose sequence number is at or below `commit_seq` leaves the head of the load ring at the next edge, several in one cycle if needed.
- R7: When `commit_valid` is high, stores at or below `commit_seq` are marked ready. `st_retire` frees the head store only when it is ready. Otherwise `st_retire` has no effect.
- R8: When `squash_valid` is high, every load younger than `squash_seq` is removed from the tail end.
- R9: The store squash removes stores younger than `squash_seq` from the tail end, but stops at the first store marked ready, even when that store is younger.
- R10: A squash takes priority. In a squash cycle the dispatch is refused, and commit and `st_retire` are ignored.
- R11: After reset both rings are empty, both tails are 0 and `free_count` equals the smaller depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_seq | input | 16 | Sequence number of the dispatched operation |
| commit_valid | input | 1 | Commit strobe |
| commit_seq | input | 16 | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | 16 | Entries younger than this are discarded |
| st_retire | input | 1 | Free the head store if it is ready |
| disp_accept | output | 1 | Dispatch taken this cycle |
| disp_idx | output | 3 | Slot assigned in the target ring |
| disp_link_idx | output | 3 | Tail of the other ring |
| disp_link_none | output | 1 | Load sees an empty store ring |
| free_count | output | 3 | Operations of either kind that can still be accepted |
| lq_used | output | 3 | Live loads |
| sq_used | output | 3 | Live stores |

## Verification
The collisions that matter are a squash arriving in the same cycle as a dispatch, and a commit arriving in the same cycle as a dispatch. The bench drives a dispatch together with a squash on a ring that has room. It expects a refusal, and it expects the tail after the squash to be the rewound one with no trace of the refused operation. It also drives commit together with dispatch. There it expects the head to pop and the tail to advance at the same edge, so that occupancy changes by the difference. A behavioural queue model in the bench predicts every output on every cycle, through directed cases and a long random mix.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Advance an index by n slots in a ring of the given size (n < ring).
  function automatic int unsigned ring_add(int unsigned idx, int unsigned n,
                                           int unsigned ring);
    int unsigned t;
    t = idx + n;
    return (t >= ring) ? t - ring : t;
  endfunction

  // Number of slots from head up to (not including) tail.
  function automatic int unsigned ring_dist(int unsigned head, int unsigned tail,
                                            int unsigned ring);
    return (tail >= head) ? tail - head : tail + ring - head;
  endfunction

  function automatic int unsigned min_u(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_ring.sv
module seq_ring
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 16,
  parameter bit HAS_WB = 1'b0,
  localparam int RING  = DEPTH + 1,
  localparam int IW    = $clog2(RING),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             commit_v,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_v,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             drain,
  output logic [IW-1:0]    head,
  output logic [IW-1:0]    tail,
  output logic [CW-1:0]    used,
  output logic             full,
  output logic             empty
);

  logic [SEQ_W-1:0] seq_q [RING];
  logic [RING-1:0]  rdy_q, rdy_d;
  logic [RING-1:0]  live_vec, mark_vec;
  logic [CW-1:0]    le_cnt, keep_cnt, n_pop;
  logic             head_ready;

  assign full       = (IW'(ring_add(int'(tail), 1, RING)) == head);
  assign empty      = (used == '0);
  assign head_ready = rdy_q[head];

  always_comb begin
    le_cnt   = '0;
    keep_cnt = '0;
    live_vec = '0;
    mark_vec = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] slot;
      slot = IW'(ring_add(int'(head), k, RING));
      if (CW'(k) < used) begin
        live_vec[slot] = 1'b1;
        if (seq_q[slot] <= commit_seq) begin
          le_cnt         = le_cnt + CW'(1);
          mark_vec[slot] = 1'b1;
        end
        if (seq_q[slot] <= squash_seq || (HAS_WB && rdy_q[slot]))
          keep_cnt = keep_cnt + CW'(1);
      end
    end
  end

  // Stores pop one ready head on drain; loads pop every committed head.
  assign n_pop = HAS_WB ? ((drain && !empty && head_ready) ? CW'(1) : '0)
                        : (commit_v ? le_cnt : '0);

  always_comb begin
    rdy_d = rdy_q;
    if (HAS_WB && commit_v) rdy_d = rdy_d | (mark_vec & live_vec);
    if (push) rdy_d[tail] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      used  <= '0;
      rdy_q <= '0;
    end else if (squash_v) begin
      tail <= IW'(ring_add(int'(head), int'(keep_cnt), RING));
      used <= keep_cnt;
    end else begin
      head  <= IW'(ring_add(int'(head), int'(n_pop), RING));
      tail  <= push ? IW'(ring_add(int'(tail), 1, RING)) : tail;
      used  <= used - n_pop + (push ? CW'(1) : CW'(0));
      rdy_q <= rdy_d;
      if (push) seq_q[tail] <= push_seq;
    end
  end

  p_push_not_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push && !squash_v |-> !full);

  p_ptr_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) == int'(ring_dist(int'(head), int'(tail), RING)));

  p_squash_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_v |=> used <= $past(used));

  generate
    if (HAS_WB) begin : g_store_chk
      p_retire_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_v && !head_ready |=> head == $past(head));
    end else begin : g_load_chk
      p_commit_pops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_v && !squash_v && !empty && seq_q[head] <= commit_seq
        |=> head != $past(head));
    end
  endgenerate

endmodule

// File: rtl/lsq_free_calc.sv
module lsq_free_calc
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  localparam int LCW = $clog2(LQ_DEPTH + 1),
  localparam int SCW = $clog2(SQ_DEPTH + 1),
  localparam int MAXD = (LQ_DEPTH > SQ_DEPTH) ? LQ_DEPTH : SQ_DEPTH,
  localparam int FW  = $clog2(MAXD + 1)
) (
  input  logic [LCW-1:0] lq_used,
  input  logic [SCW-1:0] sq_used,
  output logic [FW-1:0]  free_count
);
  assign free_count = FW'(min_u(LQ_DEPTH - int'(lq_used), SQ_DEPTH - int'(sq_used)));
endmodule

// File: rtl/lsq_alloc.sv
module lsq_alloc #(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int SEQ_W    = 16,
  localparam int LIW  = $clog2(LQ_DEPTH + 1),
  localparam int SIW  = $clog2(SQ_DEPTH + 1),
  localparam int LCW  = $clog2(LQ_DEPTH + 1),
  localparam int SCW  = $clog2(SQ_DEPTH + 1),
  localparam int IDXW = (LIW > SIW) ? LIW : SIW,
  localparam int MAXD = (LQ_DEPTH > SQ_DEPTH) ? LQ_DEPTH : SQ_DEPTH,
  localparam int FW   = $clog2(MAXD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic             disp_is_store,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             st_retire,
  output logic             disp_accept,
  output logic [IDXW-1:0]  disp_idx,
  output logic [IDXW-1:0]  disp_link_idx,
  output logic             disp_link_none,
  output logic [FW-1:0]    free_count,
  output logic [LCW-1:0]   lq_used,
  output logic [SCW-1:0]   sq_used
);

  logic [LIW-1:0] lq_head, lq_tail;
  logic [SIW-1:0] sq_head, sq_tail;
  logic lq_full, lq_empty, sq_full, sq_empty;
  logic push_ld, push_st;

  assign disp_accept = disp_valid && !squash_valid &&
                       (disp_is_store ? !sq_full : !lq_full);
  assign push_ld = disp_accept && !disp_is_store;
  assign push_st = disp_accept && disp_is_store;

  assign disp_idx       = disp_is_store ? IDXW'(sq_tail) : IDXW'(lq_tail);
  assign disp_link_idx  = disp_is_store ? IDXW'(lq_tail) : IDXW'(sq_tail);
  assign disp_link_none = !disp_is_store && sq_empty;

  seq_ring #(.DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W), .HAS_WB(1'b0)) u_loads (
    .clk(clk), .rst_n(rst_n), .push(push_ld), .push_seq(disp_seq),
    .commit_v(commit_valid), .commit_seq(commit_seq),
    .squash_v(squash_valid), .squash_seq(squash_seq), .drain(1'b0),
    .head(lq_head), .tail(lq_tail), .used(lq_used),
    .full(lq_full), .empty(lq_empty)
  );

  seq_ring #(.DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W), .HAS_WB(1'b1)) u_stores (
    .clk(clk), .rst_n(rst_n), .push(push_st), .push_seq(disp_seq),
    .commit_v(commit_valid), .commit_seq(commit_seq),
    .squash_v(squash_valid), .squash_seq(squash_seq), .drain(st_retire),
    .head(sq_head), .tail(sq_tail), .used(sq_used),
    .full(sq_full), .empty(sq_empty)
  );

  lsq_free_calc #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)) u_free (
    .lq_used(lq_used), .sq_used(sq_used), .free_count(free_count)
  );

  p_squash_no_growth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> lq_used <= $past(lq_used) && sq_used <= $past(sq_used));

  p_empty_head_is_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lq_empty |-> lq_head == lq_tail);

  p_full_means_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sq_full |-> int'(sq_used) == SQ_DEPTH);

endmodule

// File: tb/lsq_alloc_test.sv
module lsq_alloc_test;
  localparam int D = 4;
  localparam int RING = D + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 0, disp_is_store = 0, commit_valid = 0, squash_valid = 0, st_retire = 0;
  logic [15:0] disp_seq = '0, commit_seq = '0, squash_seq = '0;
  logic disp_accept, disp_link_none;
  logic [2:0] disp_idx, disp_link_idx, free_count, lq_used, sq_used;

  lsq_alloc uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_store(disp_is_store),
    .disp_seq(disp_seq), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .st_retire(st_retire),
    .disp_accept(disp_accept), .disp_idx(disp_idx), .disp_link_idx(disp_link_idx),
    .disp_link_none(disp_link_none), .free_count(free_count),
    .lq_used(lq_used), .sq_used(sq_used)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int lq[$];
  int sq[$];
  bit sqr[$];
  int lt = 0, st = 0;
  int cnt = 0, last_c = 0;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit dv, bit ds, int dseq, bit cv, int cs, bit sv, int ss, bit rt);
    bit e_acc;
    int ef;
    @(negedge clk);
    disp_valid = dv; disp_is_store = ds; disp_seq = 16'(dseq);
    commit_valid = cv; commit_seq = 16'(cs);
    squash_valid = sv; squash_seq = 16'(ss); st_retire = rt;
    #2;
    e_acc = dv && !sv && (ds ? sq.size() < D : lq.size() < D);
    chk(sv ? "R10 accept" : ((ds ? sq.size() : lq.size()) >= D ? "R1 accept" : "R2 accept"),
        int'(disp_accept), int'(e_acc));
    chk("R2 idx", int'(disp_idx), ds ? st : lt);
    chk(ds ? "R4 link" : "R3 link", int'(disp_link_idx), ds ? lt : st);
    chk(ds ? "R4 none" : "R3 none", int'(disp_link_none), int'(!ds && sq.size() == 0));
    ef = (D - lq.size() < D - sq.size()) ? D - lq.size() : D - sq.size();
    chk("R5 free", int'(free_count), ef);
    chk("R6/R8 lq_used", int'(lq_used), lq.size());
    chk("R7/R9 sq_used", int'(sq_used), sq.size());
    @(posedge clk);
    if (sv) begin
      while (lq.size() > 0 && lq[$] > ss) begin void'(lq.pop_back()); lt = (lt + RING - 1) % RING; end
      while (sq.size() > 0 && sq[$] > ss && !sqr[$]) begin
        void'(sq.pop_back()); void'(sqr.pop_back()); st = (st + RING - 1) % RING;
      end
    end else begin
      if (rt && sq.size() > 0 && sqr[0]) begin void'(sq.pop_front()); void'(sqr.pop_front()); end
      if (cv) begin
        while (lq.size() > 0 && lq[0] <= cs) void'(lq.pop_front());
        foreach (sq[i]) if (sq[i] <= cs) sqr[i] = 1'b1;
      end
      if (e_acc) begin
        if (ds) begin sq.push_back(dseq); sqr.push_back(1'b0); st = (st + 1) % RING; end
        else begin lq.push_back(dseq); lt = (lt + 1) % RING; end
      end
    end
  endtask

  task automatic disp(bit ds);
    cnt++;
    step(1, ds, cnt, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R11 free", int'(free_count), D);
    chk("R11 lq_used", int'(lq_used), 0);
    chk("R11 sq_used", int'(sq_used), 0);
    chk("R11 idx", int'(disp_idx), 0);
    // R3: load into empty store ring sees none
    disp(0);
    disp(1);                       // R4 store links to load tail 1
    disp(0); disp(0); disp(0);     // load ring now full
    disp(0);                       // R1 refused
    disp(1);                       // store 7
    step(0, 0, 0, 0, 0, 0, 0, 1);  // R7 retire before ready: ignored
    step(0, 0, 0, 1, 3, 0, 0, 0);  // R6 pops loads 1,3; marks store 2
    step(0, 0, 0, 0, 0, 0, 0, 1);  // R7 retire store 2
    last_c = 3;
    // R2 wrap: fill loads to wrap the tail
    disp(0); disp(0); disp(0);
    // commit with dispatch in the same cycle
    cnt++; step(1, 0, cnt, 1, 6, 0, 0, 0);
    last_c = 6;
    disp(1); disp(1);
    step(0, 0, 0, 1, cnt - 1, 0, 0, 0);   // R9 setup: mark older store ready
    last_c = cnt - 1;
    // R9: squash below a ready store stops there
    step(0, 0, 0, 0, 0, 1, 6, 0);
    // R10: squash with dispatch in the same cycle
    cnt++; step(1, 0, cnt, 0, 0, 1, cnt - 2, 0);
    cnt++; step(1, 1, cnt, 1, cnt - 1, 1, cnt - 1, 1);
    for (int i = 0; i < 1500; i++) begin
      int r;
      bit dv, ds, cv, sv, rt;
      int cs, ss;
      r = int'($urandom % 100);
      dv = (r < 70);
      ds = ($urandom % 2) == 1;
      cv = ($urandom % 5) == 0;
      sv = ($urandom % 12) == 0;
      rt = ($urandom % 3) == 0;
      cs = last_c + int'($urandom % 4);
      if (cs > cnt) cs = cnt;
      if (cv) last_c = cs;
      ss = last_c + int'($urandom % (cnt - last_c + 1));
      if (dv) cnt++;
      step(dv, ds, cnt, cv, cs, sv, ss, rt);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule